// File: doc/BRIEF.md
# Compare-Match Timer Unit

A two-channel timer peripheral. Each channel owns a 16-bit up-counter that advances by one on every cycle in which the shared `tick` input is high and the channel is running. Each counter is compared against two match values, A and B. Either comparison can be armed or left idle. When an armed comparison hits, the channel either wraps its count back to zero and keeps going, or it stops. A channel with both comparisons idle instead reports the counter wrapping from 0xFFFF to 0x0000.

Software reaches the unit through a byte-wide register port with a combinational read path. Three shared status registers collect the hit and wrap events, one per event kind. Each of them also holds per-channel enables. Three interrupt vectors, with one bit per channel, present the enabled events as levels.

Top module: `cmtu_timer`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) leaves every counter, match value, mode and arm register at zero, every status bit and enable at zero, every interrupt output low, and every channel running.
- R2: Channel n owns addresses CH_BASE+8n .. CH_BASE+8n+7, laid out by offset as: 0 mode, 1 arm, 2 count[15:8], 3 count[7:0], 4 match A[15:8], 5 match A[7:0], 6 match B[15:8], 7 match B[7:0]. Every byte reads back what was last written. The status registers sit at FA_ADDR (A hits), FB_ADDR (B hits) and FO_ADDR (wraps), and unused addresses read zero.
- R3: On a clock edge with `tick` high, a running channel's count becomes count+1. Without `tick`, the count holds.
- R4: Comparison A is armed only while arm bits [1:0] are nonzero. Comparison B is armed only while arm bits [5:4] are nonzero. An unarmed comparison never hits and never raises its status bit.
- R5: When an armed A comparison hits and mode bits [6:5] equal 01, the count becomes 0 and counting continues. For any other mode value, the channel stops with the count holding the hit value.
- R6: When an armed B comparison hits and mode bits [6:5] equal 10, the count becomes 0 and counting continues. For any other mode value, the channel stops with the count holding the hit value.
- R7: Within one tick, A is evaluated first. B is then compared against the count left after any A clear, and that final count is what gets stored.
- R8: A wrap is reported only when arm bits [1:0] and [5:4] are all zero and an increment produces 0x0000.
- R9: In each status register, bit n is channel n's event flag and bit n+2 is its enable. An event sets its flag. Writing 0 to a flag clears it, writing 1 to a flag leaves it unchanged, and an event in the same cycle wins over a clear. Enables are plain read/write.
- R10: `irq_a[n]`, `irq_b[n]` and `irq_ovf[n]` equal flag AND enable of the matching status register. They are levels, updated on the same edge as the flag.
- R11: A write to a channel's mode byte restarts a stopped channel.
- R12: A register write to a count byte in a cycle that also ticks stores the written byte in place of the incremented value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, one byte per cycle |
| tick | input | 1 | Count enable shared by all channels |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq_a | output | NCH | Per-channel A-hit interrupt level |
| irq_b | output | NCH | Per-channel B-hit interrupt level |
| irq_ovf | output | NCH | Per-channel wrap interrupt level |

## Verification
The bench builds the unit with its defaults: two channels, status registers at 0x00–0x02, and channel windows at 0x08 and 0x10. With two channels, the flag bits [1:0] and the enable bits [3:2] sit side by side without overlapping. This lets the bench confirm that a write of 1 to a flag next to an enable changes only the enable. It also lets the bench check that a hit on channel 1 lands on bit 1 and never on channel 0's bit. Because the counters are 16 bits wide, a wrap is reached by loading 0xFFFE rather than by counting the whole range.

// File: rtl/cmtu_timer.sv
module cmtu_timer #(
  parameter int         NCH     = 2,
  parameter logic [7:0] FA_ADDR = 8'h00,
  parameter logic [7:0] FB_ADDR = 8'h01,
  parameter logic [7:0] FO_ADDR = 8'h02,
  parameter logic [7:0] CH_BASE = 8'h08
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     addr,
  input  logic [7:0]     wdata,
  input  logic           wr,
  input  logic           tick,
  output logic [7:0]     rdata,
  output logic [NCH-1:0] irq_a,
  output logic [NCH-1:0] irq_b,
  output logic [NCH-1:0] irq_ovf
);
  localparam int EN = 2;

  logic [NCH-1:0][15:0] cnt_q, ga_q, gb_q, nxt_cnt;
  logic [NCH-1:0][7:0]  mode_q, arm_q;
  logic [NCH-1:0]       run_q, nxt_run, hit_a, hit_b, hit_o, win;
  logic [NCH-1:0]       fa_flg, fb_flg, fo_flg, fa_en, fb_en, fo_en;

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      win[n]     = (addr[7:3] == CH_BASE[7:3] + 5'(n));
      nxt_cnt[n] = cnt_q[n];
      nxt_run[n] = run_q[n];
      hit_a[n]   = 1'b0;
      hit_b[n]   = 1'b0;
      hit_o[n]   = 1'b0;
      if (tick && run_q[n]) begin
        nxt_cnt[n] = cnt_q[n] + 16'd1;
        if (arm_q[n][1:0] != 2'b00 && nxt_cnt[n] == ga_q[n]) begin
          hit_a[n] = 1'b1;
          if (mode_q[n][6:5] == 2'b01) nxt_cnt[n] = 16'd0;
          else                         nxt_run[n] = 1'b0;
        end
        if (arm_q[n][5:4] != 2'b00 && nxt_cnt[n] == gb_q[n]) begin
          hit_b[n] = 1'b1;
          if (mode_q[n][6:5] == 2'b10) nxt_cnt[n] = 16'd0;
          else                         nxt_run[n] = 1'b0;
        end
        if (arm_q[n][1:0] == 2'b00 && arm_q[n][5:4] == 2'b00 && nxt_cnt[n] == 16'd0)
          hit_o[n] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ga_q   <= '0;
      gb_q   <= '0;
      mode_q <= '0;
      arm_q  <= '0;
      run_q  <= '1;
    end else begin
      for (int n = 0; n < NCH; n++) begin
        cnt_q[n] <= nxt_cnt[n];
        run_q[n] <= nxt_run[n];
        if (wr && win[n]) begin
          case (addr[2:0])
            3'd0: begin mode_q[n] <= wdata; run_q[n] <= 1'b1; end
            3'd1: arm_q[n]        <= wdata;
            3'd2: cnt_q[n][15:8]  <= wdata;
            3'd3: cnt_q[n][7:0]   <= wdata;
            3'd4: ga_q[n][15:8]   <= wdata;
            3'd5: ga_q[n][7:0]    <= wdata;
            3'd6: gb_q[n][15:8]   <= wdata;
            default: gb_q[n][7:0] <= wdata;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa_flg <= '0; fb_flg <= '0; fo_flg <= '0;
      fa_en  <= '0; fb_en  <= '0; fo_en  <= '0;
    end else begin
      fa_flg <= ((wr && addr == FA_ADDR) ? (fa_flg & wdata[NCH-1:0]) : fa_flg) | hit_a;
      fb_flg <= ((wr && addr == FB_ADDR) ? (fb_flg & wdata[NCH-1:0]) : fb_flg) | hit_b;
      fo_flg <= ((wr && addr == FO_ADDR) ? (fo_flg & wdata[NCH-1:0]) : fo_flg) | hit_o;
      if (wr && addr == FA_ADDR) fa_en <= wdata[EN +: NCH];
      if (wr && addr == FB_ADDR) fb_en <= wdata[EN +: NCH];
      if (wr && addr == FO_ADDR) fo_en <= wdata[EN +: NCH];
    end
  end

  assign irq_a   = fa_flg & fa_en;
  assign irq_b   = fb_flg & fb_en;
  assign irq_ovf = fo_flg & fo_en;

  always_comb begin
    rdata = '0;
    if (addr == FA_ADDR) begin rdata[NCH-1:0] = fa_flg; rdata[EN +: NCH] = fa_en; end
    if (addr == FB_ADDR) begin rdata[NCH-1:0] = fb_flg; rdata[EN +: NCH] = fb_en; end
    if (addr == FO_ADDR) begin rdata[NCH-1:0] = fo_flg; rdata[EN +: NCH] = fo_en; end
    for (int n = 0; n < NCH; n++) begin
      if (win[n]) begin
        case (addr[2:0])
          3'd0: rdata = mode_q[n];
          3'd1: rdata = arm_q[n];
          3'd2: rdata = cnt_q[n][15:8];
          3'd3: rdata = cnt_q[n][7:0];
          3'd4: rdata = ga_q[n][15:8];
          3'd5: rdata = ga_q[n][7:0];
          3'd6: rdata = gb_q[n][15:8];
          default: rdata = gb_q[n][7:0];
        endcase
      end
    end
  end
endmodule

// File: rtl/cmtu_timer_chk.sv
module cmtu_timer_chk #(
  parameter int NCH = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr,
  input logic                 tick,
  input logic [NCH-1:0][15:0] cnt,
  input logic [NCH-1:0][7:0]  arm,
  input logic [NCH-1:0]       run,
  input logic [NCH-1:0]       fa,
  input logic [NCH-1:0]       fo,
  input logic [NCH-1:0]       irq_a
);
  initial AST_CHANNEL_FIT: assert (NCH >= 1 && NCH <= 2); // R9

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !wr |=> $stable(cnt[n])); // R3
    AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      tick && run[n] && !wr && arm[n][1:0] == 2'b00 && arm[n][5:4] == 2'b00
      |=> cnt[n] == $past(cnt[n]) + 16'd1); // R3
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run[n] && !wr |=> $stable(cnt[n])); // R5
    AST_WRAP_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fo[n]) |-> $past(arm[n][1:0] == 2'b00 && arm[n][5:4] == 2'b00)); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fa[n] && !wr |=> fa[n]); // R9
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_a[n]) |-> $past(tick) || $past(wr)); // R10
  end
endmodule

bind cmtu_timer cmtu_timer_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .tick(tick), .cnt(cnt_q), .arm(arm_q),
  .run(run_q), .fa(fa_flg), .fo(fo_flg), .irq_a(irq_a)
);

// File: tb/sim_cmtu_timer.sv
module sim_cmtu_timer;
  localparam int CLK_NS = 10;
  localparam logic [7:0] FA = 8'h00, FB = 8'h01, FO = 8'h02, C0 = 8'h08, C1 = 8'h10;

  logic clk = 0, rst_n = 0, tick = 0, wr = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] rdata;
  logic [1:0] irq_a, irq_b, irq_ovf;
  int checks = 0, errors = 0;
  logic done = 0;

  always #(CLK_NS/2) clk = ~clk;

  cmtu_timer u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr),
                 .tick(tick), .rdata(rdata), .irq_a(irq_a), .irq_b(irq_b), .irq_ovf(irq_ovf));

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0; tick = 0; wr = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(input logic [7:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rcnt(input logic [7:0] base, output logic [15:0] v);
    logic [7:0] h, l;
    rreg(base + 8'd2, h); rreg(base + 8'd3, l);
    v = {h, l};
  endtask

  task automatic ticks(input int k);
    @(negedge clk); tick = 1;
    repeat (k) @(negedge clk);
    tick = 0;
  endtask

  task automatic t_reset;
    logic [15:0] v; logic [7:0] b;
    do_reset;
    rcnt(C0, v); chk("R1 ch0 count", v, 16'h0);
    rcnt(C1, v); chk("R1 ch1 count", v, 16'h0);
    rreg(FA, b); chk("R1 A status", {8'h0, b}, 16'h0);
    rreg(FO, b); chk("R1 wrap status", {8'h0, b}, 16'h0);
    chk("R1 irqs", {10'h0, irq_a, irq_b, irq_ovf}, 16'h0);
  endtask

  task automatic t_readback;
    logic [7:0] b;
    do_reset;
    wreg(C1 + 8'd4, 8'h12); wreg(C1 + 8'd5, 8'h34);
    wreg(C1 + 8'd7, 8'hA5); wreg(C1 + 8'd1, 8'h22);
    rreg(C1 + 8'd4, b); chk("R2 ch1 A hi", {8'h0, b}, 16'h12);
    rreg(C1 + 8'd5, b); chk("R2 ch1 A lo", {8'h0, b}, 16'h34);
    rreg(C1 + 8'd7, b); chk("R2 ch1 B lo", {8'h0, b}, 16'hA5);
    rreg(C1 + 8'd1, b); chk("R2 ch1 arm", {8'h0, b}, 16'h22);
    rreg(C0 + 8'd5, b); chk("R2 ch0 A lo untouched", {8'h0, b}, 16'h0);
    rreg(8'h40, b); chk("R2 unused address", {8'h0, b}, 16'h0);
  endtask

  task automatic t_count;
    logic [15:0] v;
    do_reset;
    ticks(5);
    rcnt(C0, v); chk("R3 five ticks", v, 16'd5);
    repeat (3) @(negedge clk);
    rcnt(C0, v); chk("R3 hold without tick", v, 16'd5);
  endtask

  task automatic t_arm;
    logic [15:0] v; logic [7:0] b;
    do_reset;
    wreg(C0 + 8'd5, 8'd3); wreg(C0 + 8'd7, 8'd3);
    ticks(5);
    rcnt(C0, v); chk("R4 unarmed no halt", v, 16'd5);
    rreg(FA, b); chk("R4 unarmed A flag", {8'h0, b}, 16'h0);
    rreg(FB, b); chk("R4 unarmed B flag", {8'h0, b}, 16'h0);
  endtask

  task automatic t_clear_a;
    logic [15:0] v; logic [7:0] b;
    do_reset;
    wreg(C0 + 8'd5, 8'd4); wreg(C0 + 8'd1, 8'h01); wreg(C0, 8'h20);
    ticks(6);
    rcnt(C0, v); chk("R5 A clear and run", v, 16'd2);
    rreg(FA, b); chk("R5 A flag ch0", {8'h0, b}, 16'h01);
    do_reset;
    wreg(C0 + 8'd5, 8'd4); wreg(C0 + 8'd1, 8'h02); wreg(C0, 8'h40);
    ticks(6);
    rcnt(C0, v); chk("R5 A halt", v, 16'd4);
    wreg(C0, 8'h00);
    ticks(2);
    rcnt(C0, v); chk("R11 restart after mode write", v, 16'd6);
  endtask

  task automatic t_clear_b;
    logic [15:0] v; logic [7:0] b;
    do_reset;
    wreg(C1 + 8'd7, 8'd3); wreg(C1 + 8'd1, 8'h10); wreg(C1, 8'h40);
    ticks(5);
    rcnt(C1, v); chk("R6 B clear and run", v, 16'd2);
    rreg(FB, b); chk("R6 B flag ch1", {8'h0, b}, 16'h02);
    chk("R10 irq_b masked", {14'h0, irq_b}, 16'h0);
    wreg(FB, 8'h0A);
    chk("R10 irq_b enabled", {14'h0, irq_b}, 16'h2);
    do_reset;
    wreg(C1 + 8'd7, 8'd3); wreg(C1 + 8'd1, 8'h30); wreg(C1, 8'h20);
    ticks(5);
    rcnt(C1, v); chk("R6 B halt", v, 16'd3);
  endtask

  task automatic t_order;
    logic [15:0] v; logic [7:0] b;
    do_reset;
    wreg(C0 + 8'd5, 8'd2); wreg(C0 + 8'd1, 8'h11); wreg(C0, 8'h20);
    ticks(2);
    rcnt(C0, v); chk("R7 A clear then B hit", v, 16'd0);
    rreg(FB, b); chk("R7 B flag after A clear", {8'h0, b}, 16'h01);
    ticks(3);
    rcnt(C0, v); chk("R7 halted by B", v, 16'd0);
  endtask

  task automatic t_ovf;
    logic [15:0] v; logic [7:0] b;
    do_reset;
    wreg(C0 + 8'd2, 8'hFF); wreg(C0 + 8'd3, 8'hFE);
    ticks(1);
    rreg(FO, b); chk("R8 no wrap at FFFF", {8'h0, b}, 16'h0);
    ticks(1);
    rcnt(C0, v); chk("R8 wrapped count", v, 16'h0);
    rreg(FO, b); chk("R8 wrap flag", {8'h0, b}, 16'h01);
    do_reset;
    wreg(C0 + 8'd1, 8'h01); wreg(C0 + 8'd4, 8'h12); wreg(C0 + 8'd5, 8'h34);
    wreg(C0 + 8'd2, 8'hFF); wreg(C0 + 8'd3, 8'hFF);
    ticks(1);
    rcnt(C0, v); chk("R8 armed wrap count", v, 16'h0);
    rreg(FO, b); chk("R8 armed no wrap flag", {8'h0, b}, 16'h0);
  endtask

  task automatic t_flags;
    logic [7:0] b;
    do_reset;
    wreg(C0 + 8'd2, 8'hFF); wreg(C0 + 8'd3, 8'hFF);
    ticks(1);
    chk("R10 wrap masked", {14'h0, irq_ovf}, 16'h0);
    wreg(FO, 8'h05);
    rreg(FO, b); chk("R9 write 1 keeps flag", {8'h0, b}, 16'h05);
    chk("R10 wrap irq level", {14'h0, irq_ovf}, 16'h1);
    wreg(FO, 8'h04);
    rreg(FO, b); chk("R9 write 0 clears flag", {8'h0, b}, 16'h04);
    chk("R10 irq drops", {14'h0, irq_ovf}, 16'h0);
    wreg(FO, 8'h06);
    rreg(FO, b); chk("R9 write 1 cannot set flag", {8'h0, b}, 16'h04);
  endtask

  task automatic t_wr_priority;
    logic [15:0] v;
    do_reset;
    @(negedge clk); tick = 1; addr = C0 + 8'd3; wdata = 8'h80; wr = 1;
    @(negedge clk); tick = 0; wr = 0;
    rcnt(C0, v); chk("R12 write beats tick", v, 16'h0080);
    ticks(1);
    rcnt(C0, v); chk("R12 count resumes", v, 16'h0081);
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_readback;
    t_count;
    t_arm;
    t_clear_a;
    t_clear_b;
    t_order;
    t_ovf;
    t_flags;
    t_wr_priority;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule